// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block is the control front end of a behavioural DDR2-style SDRAM model on the device side. On every rising clock edge it samples chip select, the three active-low command strobes, a 3-bit bank address and a 14-bit address bus. From these it decodes Activate, Read, Write, Precharge, Refresh and mode-register writes. It records which of the eight banks holds an open row, and it keeps the latency and burst settings.

A Read or Write that is legal schedules a one-cycle start strobe for the downstream data path. The read strobe follows the read latency, which is the sum of the additive latency and the CAS latency. The write strobe comes one clock sooner. A separate output gives the burst duration in clocks. A command that breaks the bank rules produces a one-cycle error pulse and changes no state.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: Reset clears every bank to closed, sets CAS latency 4, additive latency 0, burst length 4 and sequential order, and holds all strobes and the error output low.
- R2: A cycle sampled with cs_n high has no effect on bank state, settings or strobes, whatever the other inputs carry.
- R3: Commands decode from active-low (ras_n, cas_n, we_n) with cs_n low as follows: 011 Activate, 101 Read, 100 Write, 010 Precharge, 001 Refresh, 000 mode write; 111 is a no-operation. Refresh and no-operation change nothing.
- R4: Activate to a closed bank opens it.
- R5: Precharge with addr[10] low closes only bank ba. With addr[10] high it closes all eight banks. Precharge of a closed bank is legal.
- R6: A Read or Write to an open bank with addr[10] high closes that bank at the same edge, which is auto-precharge.
- R7: A Read or Write to a closed bank, or an Activate to an open bank, drives err high for exactly the cycle after the sampling edge. It leaves the bank state unchanged and schedules no strobe.
- R8: A legal Read sampled at edge k drives rd_start high for the single cycle that begins at edge k+RL, with RL = CAS latency + additive latency taken at edge k.
- R9: A legal Write sampled at edge k drives wr_start high for the cycle that begins at edge k+RL-1.
- R10: A mode write with ba=0 takes addr[2:0]=010 as burst length 4 and 011 as burst length 8 (other codes keep the old length), takes addr[3] as the order (1 = interleaved), and takes addr[6:4] as CAS latency when it is 4, 5 or 6.
- R11: A mode write with ba=1 takes addr[5:3] as additive latency when it is 0 to 4. Any other value keeps the previous setting. A mode write with ba=2 or 3 has no effect.
- R12: burst_clks reads 2 for burst length 4 and 4 for burst length 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / mode register select |
| addr | input | 14 | Row, column or op-code |
| bank_open | output | 8 | One bit per bank, high when a row is open |
| err | output | 1 | Illegal-sequence pulse |
| rd_start | output | 1 | Read burst start strobe |
| wr_start | output | 1 | Write burst start strobe |
| burst_clks | output | 3 | Burst duration in clocks |
| cas_lat | output | 3 | Current CAS latency |
| add_lat | output | 3 | Current additive latency |
| burst_len8 | output | 1 | High for burst length 8 |
| burst_ilv | output | 1 | High for interleaved order |

## Verification
A directed opening walks through legal open, access and close sequences at the default latency and then at the largest latency. It sets strobe timing apart from off-by-one placement, and it separates single-bank precharge from precharge-all by the A10 bit. Illegal latency and burst codes appear next to legal ones, so that rejection can be told apart from a field being ignored altogether. Weighted random traffic follows, limited to a few banks so that opens on open banks and accesses to closed banks occur often. It mixes in deselected cycles that carry real command patterns and mode writes with random op-codes. This shows whether masking, errors and retimed strobes interact correctly while latency changes under pending bursts.

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker #(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14,
  parameter int CL_MIN = 4,
  parameter int CL_MAX = 6,
  parameter int AL_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [(1<<BA_W)-1:0] bank_open,
  output logic              err,
  output logic              rd_start,
  output logic              wr_start,
  output logic [2:0]        burst_clks,
  output logic [2:0]        cas_lat,
  output logic [2:0]        add_lat,
  output logic              burst_len8,
  output logic              burst_ilv
);
  localparam int NBANK = 1 << BA_W;
  localparam int PW    = CL_MAX + AL_MAX + 1;

  logic [PW-1:0] rd_pipe, wr_pipe;

  wire sel    = !cs_n;
  wire is_act = sel && !ras_n &&  cas_n &&  we_n;
  wire is_rd  = sel &&  ras_n && !cas_n &&  we_n;
  wire is_wr  = sel &&  ras_n && !cas_n && !we_n;
  wire is_pre = sel && !ras_n &&  cas_n && !we_n;
  wire is_mrs = sel && !ras_n && !cas_n && !we_n;

  wire       hit  = bank_open[ba];
  wire       bad  = (is_act && hit) || ((is_rd || is_wr) && !hit);
  wire [3:0] rl   = 4'(cas_lat) + 4'(add_lat);
  wire       go_rd = is_rd && !bad;
  wire       go_wr = is_wr && !bad;

  wire [PW-1:0] rd_new = go_rd ? (PW'(1) << rl)        : '0;
  wire [PW-1:0] wr_new = go_wr ? (PW'(1) << (rl - 4'd1)) : '0;

  wire [2:0] cl_code = addr[6:4];
  wire [2:0] al_code = addr[5:3];
  wire       cl_ok   = (32'(cl_code) >= CL_MIN) && (32'(cl_code) <= CL_MAX);
  wire       al_ok   = 32'(al_code) <= AL_MAX;

  assign rd_start   = rd_pipe[0];
  assign wr_start   = wr_pipe[0];
  assign burst_clks = burst_len8 ? 3'd4 : 3'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open  <= '0;
      err        <= 1'b0;
      rd_pipe    <= '0;
      wr_pipe    <= '0;
      cas_lat    <= 3'(CL_MIN);
      add_lat    <= 3'd0;
      burst_len8 <= 1'b0;
      burst_ilv  <= 1'b0;
    end else begin
      err     <= bad;
      rd_pipe <= (rd_pipe >> 1) | rd_new;
      wr_pipe <= (wr_pipe >> 1) | wr_new;
      if (is_act && !bad)
        bank_open[ba] <= 1'b1;
      else if (is_pre && addr[10])
        bank_open <= '0;
      else if (is_pre)
        bank_open[ba] <= 1'b0;
      else if ((go_rd || go_wr) && addr[10])
        bank_open[ba] <= 1'b0;
      if (is_mrs && ba == BA_W'(0)) begin
        if (addr[2:0] == 3'b010) burst_len8 <= 1'b0;
        else if (addr[2:0] == 3'b011) burst_len8 <= 1'b1;
        burst_ilv <= addr[3];
        if (cl_ok) cas_lat <= cl_code;
      end
      if (is_mrs && ba == BA_W'(1) && al_ok)
        add_lat <= al_code;
    end
  end

  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(bank_open) && !err && $stable(cas_lat) && $stable(add_lat)));

  p_err_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> bank_open == $past(bank_open));

  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !hit) |=> bank_open[$past(ba)]);

  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && addr[10]) |=> bank_open == '0);

  p_cl_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cas_lat) >= CL_MIN) && (32'(cas_lat) <= CL_MAX));

  p_al_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(add_lat) <= AL_MAX);

  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rd_pipe[1]) |=> !rd_start);

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      p_closed_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_open[g] && !(is_act && ba == BA_W'(g))) |=> !bank_open[g]);
    end
  endgenerate
endmodule

// File: tb/ddr2_cmd_tracker_test.sv
module ddr2_cmd_tracker_test;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [2:0] ba = 0;
  logic [13:0] addr = 0;
  logic [7:0] bank_open;
  logic err, rd_start, wr_start, burst_len8, burst_ilv;
  logic [2:0] burst_clks, cas_lat, add_lat;

  ddr2_cmd_tracker uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
    .err(err), .rd_start(rd_start), .wr_start(wr_start), .burst_clks(burst_clks),
    .cas_lat(cas_lat), .add_lat(add_lat), .burst_len8(burst_len8), .burst_ilv(burst_ilv));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [7:0] m_open = 0;
  int m_cl = 4, m_al = 0;
  bit m_bl8 = 0, m_ilv = 0, m_err = 0;
  bit rd_s [64];
  bit wr_s [64];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit cl_legal(int v); return v >= 4 && v <= 6; endfunction
  function automatic bit al_legal(int v); return v <= 4; endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_all();
    check("R4/R5/R6 bank_open", bank_open, m_open);
    check("R7 err", err, m_err);
    check("R8 rd_start", rd_start, rd_s[cyc % 64]);
    check("R9 wr_start", wr_start, wr_s[cyc % 64]);
    check("R10 cas_lat", cas_lat, m_cl);
    check("R11 add_lat", add_lat, m_al);
    check("R10 burst_len8", burst_len8, m_bl8);
    check("R10 burst_ilv", burst_ilv, m_ilv);
    check("R12 burst_clks", burst_clks, m_bl8 ? 4 : 2);
    rd_s[cyc % 64] = 0;
    wr_s[cyc % 64] = 0;
  endtask

  // called at a negedge; returns at the following negedge after checks
  task automatic step(bit c, bit r, bit ca, bit w, logic [2:0] b, logic [13:0] a);
    bit act, rd, wr, pre, mrs;
    int rl;
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(posedge clk);
    cyc++;
    act = !c && !r && ca && w;
    rd  = !c && r && !ca && w;
    wr  = !c && r && !ca && !w;
    pre = !c && !r && ca && !w;
    mrs = !c && !r && !ca && !w;
    m_err = (act && m_open[b]) || ((rd || wr) && !m_open[b]);
    rl = m_cl + m_al;
    if (rd && !m_err) rd_s[(cyc + rl) % 64] = 1;
    if (wr && !m_err) wr_s[(cyc + rl - 1) % 64] = 1;
    if (act && !m_err) m_open[b] = 1;
    if (pre) begin
      if (a[10]) m_open = 0; else m_open[b] = 0;
    end
    if ((rd || wr) && !m_err && a[10]) m_open[b] = 0;
    if (mrs && b == 0) begin
      if (a[2:0] == 3'b010) m_bl8 = 0;
      if (a[2:0] == 3'b011) m_bl8 = 1;
      m_ilv = a[3];
      if (cl_legal(int'(a[6:4]))) m_cl = int'(a[6:4]);
    end
    if (mrs && b == 1 && al_legal(int'(a[5:3]))) m_al = int'(a[5:3]);
    @(negedge clk);
    check_all();
  endtask

  task automatic nop(); step(0, 1, 1, 1, 0, 0); endtask
  task automatic act_b(logic [2:0] b); step(0, 0, 1, 1, b, 14'h123); endtask
  task automatic rd_b(logic [2:0] b, bit ap); step(0, 1, 0, 1, b, ap ? 14'h0400 : 14'h0010); endtask
  task automatic wr_b(logic [2:0] b, bit ap); step(0, 1, 0, 0, b, ap ? 14'h0400 : 14'h0020); endtask
  task automatic pre_b(logic [2:0] b, bit all); step(0, 0, 1, 0, b, all ? 14'h0400 : 14'h0000); endtask
  task automatic mrs_b(logic [2:0] b, logic [13:0] a); step(0, 0, 0, 0, b, a); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0d12));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 bank_open", bank_open, 0);
    check("R1 cas_lat", cas_lat, 4);
    check("R1 add_lat", add_lat, 0);
    check("R1 burst_len8", burst_len8, 0);
    check("R1 burst_ilv", burst_ilv, 0);
    check("R1 strobes", {err, rd_start, wr_start}, 0);
    rst_n = 1;
    // R4, R8, R9 at default latency
    act_b(2);
    rd_b(2, 0);
    wr_b(2, 0);
    repeat (5) nop();
    // R7: access closed bank, activate open bank
    rd_b(5, 0);
    wr_b(6, 0);
    act_b(2);
    nop();
    // R2: deselected activate/precharge-all patterns
    step(1, 0, 1, 1, 3, 0);
    step(1, 0, 1, 0, 2, 14'h0400);
    step(1, 0, 0, 0, 0, 14'h0063);
    check("R2 bank2 still open", bank_open[2], 1);
    // R3: refresh no effect
    step(0, 0, 0, 1, 2, 0);
    // R10: CL6, BL8, interleave; R11: AL4 -> RL 10
    mrs_b(0, 14'h006B);
    mrs_b(1, 14'h0020);
    rd_b(2, 0);
    wr_b(2, 0);
    repeat (12) nop();
    // R10/R11 rejections
    mrs_b(0, 14'h0075);
    mrs_b(1, 14'h0028);
    mrs_b(2, 14'h004A);
    mrs_b(3, 14'h0018);
    mrs_b(0, 14'h0052);
    mrs_b(1, 14'h0000);
    // R6 auto-precharge; R5 single vs all
    act_b(4);
    rd_b(4, 1);
    rd_b(4, 0);
    act_b(1); act_b(3); act_b(7);
    pre_b(3, 0);
    pre_b(0, 0);
    pre_b(5, 1);
    act_b(6);
    wr_b(6, 1);
    repeat (8) nop();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 16;
      logic [2:0] b = 3'($urandom % 4);
      logic [13:0] a = 14'($urandom);
      case (op)
        0, 1, 2:  step(0, 0, 1, 1, b, a);
        3, 4, 5:  step(0, 1, 0, 1, b, a);
        6, 7, 8:  step(0, 1, 0, 0, b, a);
        9, 10:    step(0, 0, 1, 0, b, a);
        11:       step(0, 0, 0, 1, b, a);
        12:       step(0, 0, 0, 0, 3'($urandom % 4), a);
        13:       step(1, 1'($urandom), 1'($urandom), 1'($urandom), b, a);
        default:  nop();
      endcase
    end
    repeat (12) nop();
    finish_run();
  end
endmodule